// File: doc/BRIEF.md
# Return-Address Stack Filter for Branch Trace

This block sits in the ingress path of a branch trace encoder. On every cycle in which `in_valid` is high it takes a 4-bit instruction type, the address of the instruction that closes the current block, that instruction's size, and the PC presented on that cycle. From these it decides which control transfers must be reported with an indirect-branch message and which ones a decoder can infer without one.

Calls push their predicted return address onto a small hardware stack. A return, or a co-routine swap, pops that stack. The popped address is then compared with the PC of the next valid ingress cycle. When the two match, no message is needed. When they differ, or when the stack was empty, the block requests a deferred return message. Indirect calls and indirect jumps always request a message. Every transfer type (codes 8 to 15) also raises a strobe that tells the encoder to refresh its instruction-count field.

The comparison is tracked by a two-state machine:
- `ST_IDLE` means no return is waiting for its target.
- `ST_WAIT_TGT` means a popped address, or an empty-pop marker, is held until the next valid cycle.

Its transitions are:
- `ST_IDLE` to `ST_WAIT_TGT` on a valid return or swap.
- `ST_WAIT_TGT` to `ST_IDLE` on a valid cycle of any other type. This is the resolve step.
- `ST_WAIT_TGT` to `ST_WAIT_TGT` on a valid return or swap. This resolves the held address and captures a new one.
- Any state holds on an idle cycle.

Top module: `ret_stack_filter`

## Requirements
- R1: After reset all outputs are low, the stack is empty and the state is `ST_IDLE`.
- R2: `cnt_upd` is high in the cycle after each valid ingress cycle whose type is 8 to 15. It is low after valid cycles of type 0 to 7 and after idle cycles.
- R3: `br_msg_req` is high in the cycle after a valid cycle of type 8 (indirect call), 10 (indirect jump) or 14 (indirect jump with linkage). It stays low for types 9, 11, 12, 13 and 15.
- R4: Types 8 and 9 push `in_iaddr + 4` when `in_size4` is 1, and `in_iaddr + 2` when it is 0.
- R5: Type 13 (return) pops the stack. In the cycle after the next valid ingress cycle, `ret_msg_req` is high with `ret_msg_code` 0 if the popped address differs from that cycle's `in_pc`. It is low if the two are equal.
- R6: Idle cycles (`in_valid` low) between a return and its next valid cycle have no effect on the comparison, the stack or the outputs.
- R7: Type 12 (co-routine swap) pops and then pushes its own return address. The popped value is compared exactly as in R5.
- R8: A return or swap that finds the stack empty forces `ret_msg_req` high with `ret_msg_code` 1 after the next valid cycle, whatever the PC is.
- R9: A push onto a stack already holding `DEPTH` entries discards the oldest entry. Later pops return the newest `DEPTH` addresses, most recent first.
- R10: Types 0 to 7, 10, 11, 14 and 15 leave the stack contents unchanged.
- R11: When a return or swap is followed directly by another return or swap, the second one's valid cycle resolves the held comparison and captures a new one in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Ingress cycle carries a retired block |
| in_itype | input | 4 | Instruction type closing the block |
| in_iaddr | input | AW | Address of the closing instruction |
| in_size4 | input | 1 | 1: closing instruction is 4 bytes, 0: 2 bytes |
| in_pc | input | AW | PC presented in this ingress cycle |
| cnt_upd | output | 1 | Refresh instruction-count field |
| br_msg_req | output | 1 | Request indirect-branch message for a call or jump |
| ret_msg_req | output | 1 | Request indirect-branch message for an unpredicted return |
| ret_msg_code | output | 1 | 0: address mismatch, 1: stack was empty |

## Verification
The bench builds the block with `DEPTH` = 2 and a 16-bit address width. Three calls in a row are then enough to overflow the stack and reach the oldest-entry discard, and a third return after two matching returns is enough to reach the empty-pop path. The narrow address keeps the pseudo-random phase producing frequent matching and mismatching PCs. The reference model chooses the matching PC from its own queue about half the time.

// File: rtl/rsf_pkg.sv
package rsf_pkg;

    typedef enum logic [3:0] {
        IT_NONE    = 4'd0,
        IT_EXC     = 4'd1,
        IT_INTR    = 4'd2,
        IT_TRET    = 4'd3,
        IT_BR_NT   = 4'd4,
        IT_BR_T    = 4'd5,
        IT_RSV6    = 4'd6,
        IT_RSV7    = 4'd7,
        IT_ICALL   = 4'd8,
        IT_DCALL   = 4'd9,
        IT_IJMP    = 4'd10,
        IT_DJMP    = 4'd11,
        IT_SWAP    = 4'd12,
        IT_RET     = 4'd13,
        IT_IJMP_LK = 4'd14,
        IT_DJMP_LK = 4'd15
    } itype_e;

    typedef enum logic {
        ST_IDLE,
        ST_WAIT_TGT
    } fstate_e;

    localparam logic CODE_MISMATCH = 1'b0;
    localparam logic CODE_EMPTY    = 1'b1;

endpackage

// File: rtl/rsf_decode.sv
module rsf_decode
    import rsf_pkg::*;
(
    input  logic [3:0] itype,
    output logic       do_push,
    output logic       do_pop,
    output logic       ind_msg,
    output logic       xfer
);

    always_comb begin
        do_push = 1'b0;
        do_pop  = 1'b0;
        ind_msg = 1'b0;
        xfer    = 1'b0;
        unique case (itype_e'(itype))
            IT_ICALL: begin
                do_push = 1'b1;
                ind_msg = 1'b1;
                xfer    = 1'b1;
            end
            IT_DCALL: begin
                do_push = 1'b1;
                xfer    = 1'b1;
            end
            IT_IJMP, IT_IJMP_LK: begin
                ind_msg = 1'b1;
                xfer    = 1'b1;
            end
            IT_DJMP, IT_DJMP_LK: begin
                xfer    = 1'b1;
            end
            IT_SWAP: begin
                do_pop  = 1'b1;
                do_push = 1'b1;
                xfer    = 1'b1;
            end
            IT_RET: begin
                do_pop  = 1'b1;
                xfer    = 1'b1;
            end
            IT_NONE, IT_EXC, IT_INTR, IT_TRET,
            IT_BR_NT, IT_BR_T, IT_RSV6, IT_RSV7: begin
                xfer    = 1'b0;
            end
            default: begin
                xfer    = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/rsf_stack.sv
module rsf_stack #(
    parameter int AW    = 32,
    parameter int DEPTH = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic          pop,
    input  logic [AW-1:0] push_addr,
    output logic [AW-1:0] top_addr,
    output logic          empty
);

    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);
    localparam logic [CW-1:0] FULL = CW'(DEPTH);

    logic [AW-1:0] mem [DEPTH];
    logic [PW-1:0] wr_ptr;
    logic [PW-1:0] top_ptr;
    logic [CW-1:0] count;

    assign top_ptr  = (wr_ptr == '0) ? LAST : wr_ptr - 1'b1;
    assign top_addr = mem[top_ptr];
    assign empty    = (count == '0);

    // Pointer and occupancy; a swap on a non-empty stack rewrites the top.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            count  <= '0;
        end else if (push && pop && !empty) begin
            wr_ptr <= wr_ptr;
        end else if (push) begin
            wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
            if (count != FULL) begin
                count <= count + 1'b1;
            end
        end else if (pop && !empty) begin
            wr_ptr <= top_ptr;
            count  <= count - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (push && pop && !empty) begin
            mem[top_ptr] <= push_addr;
        end else if (push) begin
            mem[wr_ptr] <= push_addr;
        end
    end

    assert_depth_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
        count <= FULL);

    assert_push_fills_R4: assert property (@(posedge clk) disable iff (!rst_n)
        push |=> !empty);

    assert_pop_drains_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !push && !empty) |=> (count == $past(count) - 1'b1));

endmodule

// File: rtl/ret_stack_filter.sv
module ret_stack_filter
    import rsf_pkg::*;
#(
    parameter int AW    = 32,
    parameter int DEPTH = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [3:0]    in_itype,
    input  logic [AW-1:0] in_iaddr,
    input  logic          in_size4,
    input  logic [AW-1:0] in_pc,
    output logic          cnt_upd,
    output logic          br_msg_req,
    output logic          ret_msg_req,
    output logic          ret_msg_code
);

    localparam logic [AW-1:0] STEP2 = AW'(2);
    localparam logic [AW-1:0] STEP4 = AW'(4);

    fstate_e       state, state_nx;
    logic          dec_push, dec_pop, dec_ind, dec_xfer;
    logic          stk_push, stk_pop, stk_empty;
    logic [AW-1:0] stk_top, ret_addr;
    logic [AW-1:0] held_addr;
    logic          held_empty;
    logic          resolve;

    rsf_decode u_decode (
        .itype   (in_itype),
        .do_push (dec_push),
        .do_pop  (dec_pop),
        .ind_msg (dec_ind),
        .xfer    (dec_xfer)
    );

    assign ret_addr = in_iaddr + (in_size4 ? STEP4 : STEP2);
    assign stk_push = in_valid && dec_push;
    assign stk_pop  = in_valid && dec_pop;

    rsf_stack #(.AW(AW), .DEPTH(DEPTH)) u_stack (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (stk_push),
        .pop       (stk_pop),
        .push_addr (ret_addr),
        .top_addr  (stk_top),
        .empty     (stk_empty)
    );

    assign resolve = in_valid && (state == ST_WAIT_TGT);

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:     if (in_valid && dec_pop) state_nx = ST_WAIT_TGT;
            ST_WAIT_TGT: if (in_valid)            state_nx = dec_pop ? ST_WAIT_TGT : ST_IDLE;
            default:     state_nx = ST_IDLE;
        endcase
    end

    // State register and held comparison operand.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            held_addr  <= '0;
            held_empty <= 1'b0;
        end else begin
            state <= state_nx;
            if (stk_pop) begin
                held_addr  <= stk_top;
                held_empty <= stk_empty;
            end
        end
    end

    // Registered request outputs.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_upd      <= 1'b0;
            br_msg_req   <= 1'b0;
            ret_msg_req  <= 1'b0;
            ret_msg_code <= CODE_MISMATCH;
        end else begin
            cnt_upd      <= in_valid && dec_xfer;
            br_msg_req   <= in_valid && dec_ind;
            ret_msg_req  <= resolve && (held_empty || (held_addr != in_pc));
            ret_msg_code <= (resolve && held_empty) ? CODE_EMPTY : CODE_MISMATCH;
        end
    end

    assert_ret_after_valid_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ret_msg_req |-> $past(in_valid));

    assert_wait_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT_TGT && !in_valid) |=> (state == ST_WAIT_TGT));

    assert_br_with_cnt_R3: assert property (@(posedge clk) disable iff (!rst_n)
        br_msg_req |-> cnt_upd);

    assert_empty_code_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ret_msg_code |-> ret_msg_req);

    assert_ret_with_cnt_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ret_msg_req |-> $past(state == ST_WAIT_TGT));

endmodule

// File: tb/ret_stack_filter_bench.sv
module ret_stack_filter_bench;

    localparam int AW    = 16;
    localparam int DEPTH = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [3:0]    in_itype = '0;
    logic [AW-1:0] in_iaddr = '0;
    logic          in_size4 = 1'b0;
    logic [AW-1:0] in_pc = '0;
    logic          cnt_upd, br_msg_req, ret_msg_req, ret_msg_code;

    ret_stack_filter #(.AW(AW), .DEPTH(DEPTH)) u_ret_stack_filter (
        .clk          (clk),
        .rst_n        (rst_n),
        .in_valid     (in_valid),
        .in_itype     (in_itype),
        .in_iaddr     (in_iaddr),
        .in_size4     (in_size4),
        .in_pc        (in_pc),
        .cnt_upd      (cnt_upd),
        .br_msg_req   (br_msg_req),
        .ret_msg_req  (ret_msg_req),
        .ret_msg_code (ret_msg_code)
    );

    always #4ns clk = ~clk;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // Reference model state
    logic [AW-1:0] stk[$];
    bit            pend = 1'b0;
    bit            pend_emp = 1'b0;
    logic [AW-1:0] pend_a = '0;
    logic          exp_cnt = 1'b0, exp_br = 1'b0, exp_ret = 1'b0, exp_code = 1'b0;
    string         ph = "R5";
    string         ret_tag = "R1";

    task automatic chk(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0b expected %0b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare();
        chk("R2 cnt_upd", cnt_upd, exp_cnt);
        chk("R3 br_msg_req", br_msg_req, exp_br);
        chk({ret_tag, " ret_msg_req"}, ret_msg_req, exp_ret);
        chk({ret_tag, " ret_msg_code"}, ret_msg_code, exp_code);
    endtask

    task automatic model(input logic v, input logic [3:0] it, input logic [AW-1:0] ia,
                         input logic s4, input logic [AW-1:0] pc);
        exp_cnt  = v && (it >= 4'd8);
        exp_br   = v && (it == 4'd8 || it == 4'd10 || it == 4'd14);
        exp_ret  = 1'b0;
        exp_code = 1'b0;
        ret_tag  = ph;
        if (v) begin
            if (pend) begin
                exp_ret  = pend_emp || (pend_a != pc);
                exp_code = pend_emp;
                ret_tag  = pend_emp ? "R8" : ph;
                pend     = 1'b0;
            end
            if (it == 4'd12 || it == 4'd13) begin
                pend = 1'b1;
                if (stk.size() == 0) begin
                    pend_emp = 1'b1;
                end else begin
                    pend_emp = 1'b0;
                    pend_a   = stk.pop_back();
                end
            end
            // R4 / R9: push return address, oldest dropped when full
            if (it == 4'd8 || it == 4'd9 || it == 4'd12) begin
                if (stk.size() == DEPTH) void'(stk.pop_front());
                stk.push_back(ia + (s4 ? 16'd4 : 16'd2));
            end
        end
    endtask

    task automatic step(input logic v, input logic [3:0] it, input logic [AW-1:0] ia,
                        input logic s4, input logic [AW-1:0] pc);
        @(negedge clk);
        compare();
        in_valid = v;
        in_itype = it;
        in_iaddr = ia;
        in_size4 = s4;
        in_pc    = pc;
        model(v, it, ia, s4, pc);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(1'b0, 4'd13, 16'hDEAD, 1'b1, 16'hBEEF);
    endtask

    logic [15:0] lfsr = 16'hACE1;

    function automatic logic [15:0] nxt(input logic [15:0] s);
        return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        ph = "R1";
        ret_tag = "R1";
        // R1: reset values
        chk("R1 cnt_upd", cnt_upd, 1'b0);
        chk("R1 br_msg_req", br_msg_req, 1'b0);
        chk("R1 ret_msg_req", ret_msg_req, 1'b0);
        chk("R1 ret_msg_code", ret_msg_code, 1'b0);
        rst_n = 1'b1;
        // R1/R8: stack empty right after reset
        step(1'b1, 4'd13, 16'h0040, 1'b0, 16'h0000);
        step(1'b1, 4'd0,  16'h0050, 1'b0, 16'h0044);

        // R2/R3/R10: sweep every non-stack type
        ph = "R10";
        step(1'b1, 4'd9, 16'h1000, 1'b1, 16'h0000);
        for (int t = 0; t < 16; t++) begin
            if (t != 8 && t != 9 && t != 12 && t != 13)
                step(1'b1, 4'(t), 16'h2000 + 16'(t), 1'b0, 16'h3000);
        end
        step(1'b1, 4'd13, 16'h2100, 1'b0, 16'h0000);
        step(1'b1, 4'd0,  16'h2200, 1'b0, 16'h1004);   // R10: match expected

        // R4/R5/R6: indirect call, return, idle gap, matching PC
        ph = "R6";
        step(1'b1, 4'd8,  16'h0100, 1'b1, 16'h0000);
        step(1'b1, 4'd13, 16'h0200, 1'b0, 16'h0000);
        idle(3);
        step(1'b1, 4'd4,  16'h0110, 1'b0, 16'h0104);
        // R4/R5: direct call size 2, mismatching return
        ph = "R5";
        step(1'b1, 4'd9,  16'h0300, 1'b0, 16'h0000);
        step(1'b1, 4'd13, 16'h0310, 1'b0, 16'h0000);
        step(1'b1, 4'd5,  16'h0410, 1'b0, 16'h0400);
        step(1'b0, 4'd0,  16'h0000, 1'b0, 16'h0000);

        // R9: overflow with DEPTH = 2
        ph = "R9";
        step(1'b1, 4'd9,  16'h0A00, 1'b1, 16'h0000);
        step(1'b1, 4'd8,  16'h0B00, 1'b0, 16'h0000);
        step(1'b1, 4'd9,  16'h0C00, 1'b1, 16'h0000);
        step(1'b1, 4'd13, 16'h0D00, 1'b0, 16'h0000);
        step(1'b1, 4'd13, 16'h0D10, 1'b0, 16'h0C04);   // R11: back to back
        step(1'b1, 4'd13, 16'h0D20, 1'b0, 16'h0B02);
        step(1'b1, 4'd0,  16'h0D30, 1'b0, 16'h0A04);   // R8: oldest gone

        // R7: co-routine swap
        ph = "R7";
        step(1'b1, 4'd9,  16'h0E00, 1'b1, 16'h0000);
        step(1'b1, 4'd12, 16'h0F00, 1'b1, 16'h0000);
        step(1'b1, 4'd13, 16'h0F10, 1'b0, 16'h0E04);
        step(1'b1, 4'd0,  16'h0F20, 1'b0, 16'h0F04);
        step(1'b1, 4'd12, 16'h0F30, 1'b0, 16'h0000);
        step(1'b1, 4'd0,  16'h0F40, 1'b0, 16'h1234);   // R8 via empty swap

        // Pseudo-random phase
        ph = "R11";
        for (int i = 0; i < 600; i++) begin
            logic [AW-1:0] pc;
            lfsr = nxt(lfsr);
            pc = (lfsr[6] && pend && !pend_emp) ? pend_a : {lfsr[3:0], 4'h0, lfsr[11:4]};
            step(lfsr[0] | lfsr[1], lfsr[5:2] | {lfsr[9], 3'b000},
                 {4'h0, lfsr[15:4]}, lfsr[7], pc);
        end
        step(1'b0, 4'd0, 16'h0, 1'b0, 16'h0);
        @(negedge clk);
        compare();
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule